// File: doc/BRIEF.md
# Variable-Page Data Translation Buffer

This block is a software-managed, fully associative translation buffer for data accesses. It turns a 32-bit virtual address into a physical address. It holds 64 entries. Each entry has its own page size, a power of four from 4 KB up to 16 MB. Each entry also stores an 8-bit task identifier and a write-permission bit. Software loads, replaces or invalidates one entry at a time through an indexed write port. No page-table walker or replacement logic is built in. A missing translation is reported, and software refills the buffer itself.

There are two independent lookup ports, so two load/store units can translate in the same cycle. Each request carries:
- the virtual address,
- the current task identifier,
- a store flag,
- the processor mode (supervisor or user).

The three top address bits choose a segment. A segment may be mapped through the buffer, passed through by identity, marked non-cacheable, or reserved for supervisor mode. The result of each lookup appears one clock after the request. It gives a physical address, a two-bit status and a non-cacheable flag.

Top module: `dtlb_varpage`

## Requirements
- R1: After reset, all entries are invalid and `rs_valid` is low on both ports. Any lookup to a mapped segment then returns status MISS (01).
- R2: Each port answers independently. `rs_valid[p]` is high exactly in the cycle after `lk_req[p]` was high, and the two ports may both request in the same cycle.
- R3: An entry hits only when all three hold:
  - it is valid;
  - its task identifier equals `lk_tid`;
  - its stored virtual page number equals the address bits above its page offset.
  
  A lookup with no hitting entry returns MISS (01). For any status other than OK (00), `rs_pa` is zero.
- R4: A size code c from 0 to 6 gives a page of 4 KB·4^c. The low 12+2c address bits pass unchanged into `rs_pa`, and the upper bits come from the entry's frame number. Size codes 7 behave as 6.
- R5: A store (`lk_store`=1) that hits an entry whose write permission is clear returns PROT (10). A load to that entry translates normally.
- R6: Segments are selected by address bits [31:29]:
  - 0xx: user, mapped.
  - 100: supervisor-only, identity, cacheable.
  - 101: supervisor-only, identity, non-cacheable.
  - 11x: supervisor-only, mapped.
  
  Identity segments return OK with `rs_pa` equal to the address, without consulting any entry. `rs_uncached` is high only for OK results in segment 101.
- R7: A user-mode lookup (`lk_sup`=0) to a supervisor-only segment returns PRIV (11). This status takes precedence over every other outcome.
- R8: A write with `cfg_we` stores all fields into entry `cfg_idx`. `cfg_valid`=0 invalidates that entry. Lookups requested in the same cycle as the write see the old contents; lookups from the next cycle on see the new contents.
- R9: When several entries hit, the lowest-indexed one supplies the translation and the permission.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted synchronously |
| cfg_we | input | 1 | Entry write strobe |
| cfg_idx | input | 6 | Entry index to write |
| cfg_valid | input | 1 | Valid bit written into the entry |
| cfg_vpn | input | 20 | Virtual page number (address bits 31:12) |
| cfg_ppn | input | 20 | Physical frame number (address bits 31:12) |
| cfg_size | input | 3 | Page size code, 4 KB·4^code |
| cfg_tid | input | 8 | Task identifier of the entry |
| cfg_wok | input | 1 | Write permission of the entry |
| lk_req | input | 2 | Lookup request per port |
| lk_va | input | 2x32 | Virtual address per port |
| lk_tid | input | 2x8 | Current task identifier per port |
| lk_store | input | 2 | Access is a store, per port |
| lk_sup | input | 2 | Supervisor mode, per port |
| rs_valid | output | 2 | Result valid per port |
| rs_pa | output | 2x32 | Physical address per port |
| rs_status | output | 2x2 | 00 OK, 01 MISS, 10 PROT, 11 PRIV |
| rs_uncached | output | 2 | Access is non-cacheable |

## Verification
A wrongly stored field, a bad valid bit or a bad size mask in an entry shows up in one place. It appears on the first lookup that reaches that entry, in the cycle right after the request. The symptom is a wrong address bit, or a MISS where a hit was due (or the reverse).

A fault in the priority or segment decode shows as a wrong status code on that same response cycle.

The bench uses a behavioural model built on page-size arithmetic. It compares every response in every cycle. Random writes and lookups are aimed at a few overlapping pages, so stale, shadowed and resized entries are reached within a few cycles.

// File: rtl/dtlb_pkg.sv
package dtlb_pkg;
  localparam int VA_W     = 32;
  localparam int PAGE_LSB = 12;
  localparam int VPN_W    = VA_W - PAGE_LSB;
  localparam int TID_W    = 8;
  localparam int SZ_W     = 3;
  localparam int MAX_SZ   = 6;
  localparam int SEG_W    = 3;

  typedef enum logic [1:0] {
    ST_OK   = 2'b00,
    ST_MISS = 2'b01,
    ST_PROT = 2'b10,
    ST_PRIV = 2'b11
  } dtlb_status_e;

  typedef struct packed {
    logic [VPN_W-1:0] vpn;
    logic [VPN_W-1:0] ppn;
    logic [SZ_W-1:0]  size;
    logic [TID_W-1:0] tid;
    logic             wok;
  } dtlb_map_t;

  typedef struct packed {
    logic mapped;
    logic sup_only;
    logic uncached;
  } seg_attr_t;

  // Ones on page-number bits that take part in the tag compare.
  function automatic logic [VPN_W-1:0] size_mask(input logic [SZ_W-1:0] sz);
    logic [SZ_W-1:0] c;
    c = (sz > SZ_W'(MAX_SZ)) ? SZ_W'(MAX_SZ) : sz;
    size_mask = '1;
    for (int b = 0; b < 2 * MAX_SZ; b++) begin
      if (b < 2 * int'(c)) size_mask[b] = 1'b0;
    end
  endfunction

  function automatic seg_attr_t seg_decode(input logic [SEG_W-1:0] top);
    case (top)
      3'b100:        seg_decode = '{mapped: 1'b0, sup_only: 1'b1, uncached: 1'b0};
      3'b101:        seg_decode = '{mapped: 1'b0, sup_only: 1'b1, uncached: 1'b1};
      3'b110, 3'b111: seg_decode = '{mapped: 1'b1, sup_only: 1'b1, uncached: 1'b0};
      default:       seg_decode = '{mapped: 1'b1, sup_only: 1'b0, uncached: 1'b0};
    endcase
  endfunction
endpackage

// File: rtl/dtlb_entry.sv
module dtlb_entry
  import dtlb_pkg::*;
#(
  parameter int N_ENTRIES = 64,
  parameter int SLOT      = 0,
  localparam int IDX_W    = $clog2(N_ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [IDX_W-1:0] cfg_idx,
  input  logic             cfg_valid,
  input  logic [VPN_W-1:0] cfg_vpn,
  input  logic [VPN_W-1:0] cfg_ppn,
  input  logic [SZ_W-1:0]  cfg_size,
  input  logic [TID_W-1:0] cfg_tid,
  input  logic             cfg_wok,
  output logic             ent_valid,
  output dtlb_map_t        ent_map
);
  logic      slot_sel;
  logic      valid_q, valid_d;
  dtlb_map_t map_q, map_d;

  assign slot_sel = cfg_we && (cfg_idx == IDX_W'(SLOT));

  always_comb begin
    valid_d = valid_q;
    map_d   = map_q;
    if (slot_sel) begin
      valid_d = cfg_valid;
      map_d   = '{vpn: cfg_vpn, ppn: cfg_ppn, size: cfg_size, tid: cfg_tid, wok: cfg_wok};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= valid_d;
  end

  // Payload needs no reset: it is qualified by the valid bit.
  always_ff @(posedge clk) begin
    if (slot_sel) map_q <= map_d;
  end

  assign ent_valid = valid_q;
  assign ent_map   = map_q;
endmodule

// File: rtl/dtlb_lookup.sv
module dtlb_lookup
  import dtlb_pkg::*;
#(
  parameter int N_ENTRIES = 64
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req,
  input  logic [VA_W-1:0]      va,
  input  logic [TID_W-1:0]     tid,
  input  logic                 store,
  input  logic                 sup,
  input  logic [N_ENTRIES-1:0] ents_valid,
  input  dtlb_map_t            ents [N_ENTRIES],
  output logic                 rsp_valid,
  output logic [VA_W-1:0]      pa,
  output dtlb_status_e         status,
  output logic                 uncached
);
  logic [VPN_W-1:0]     va_vpn;
  logic [N_ENTRIES-1:0] match;
  logic                 found;
  logic [VPN_W-1:0]     sel_ppn;
  logic [VPN_W-1:0]     sel_mask;
  logic                 sel_wok;
  seg_attr_t            seg;

  logic                 valid_d;
  logic [VA_W-1:0]      pa_d;
  dtlb_status_e         status_d;
  logic                 unc_d;

  assign va_vpn = va[VA_W-1:PAGE_LSB];
  assign seg    = seg_decode(va[VA_W-1 -: SEG_W]);

  for (genvar e = 0; e < N_ENTRIES; e++) begin : g_cmp
    assign match[e] = ents_valid[e] && (ents[e].tid == tid) &&
                      (((ents[e].vpn ^ va_vpn) & size_mask(ents[e].size)) == '0);
  end

  // Downward scan: the last assignment is the lowest matching index.
  always_comb begin
    found    = 1'b0;
    sel_ppn  = '0;
    sel_mask = '1;
    sel_wok  = 1'b0;
    for (int e = N_ENTRIES - 1; e >= 0; e--) begin
      if (match[e]) begin
        found    = 1'b1;
        sel_ppn  = ents[e].ppn;
        sel_mask = size_mask(ents[e].size);
        sel_wok  = ents[e].wok;
      end
    end
  end

  always_comb begin
    valid_d  = req;
    pa_d     = '0;
    status_d = ST_OK;
    unc_d    = 1'b0;
    if (seg.sup_only && !sup) begin
      status_d = ST_PRIV;
    end else if (!seg.mapped) begin
      pa_d  = va;
      unc_d = seg.uncached;
    end else if (!found) begin
      status_d = ST_MISS;
    end else if (store && !sel_wok) begin
      status_d = ST_PROT;
    end else begin
      pa_d = {(sel_ppn & sel_mask) | (va_vpn & ~sel_mask), va[PAGE_LSB-1:0]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsp_valid <= 1'b0;
    else        rsp_valid <= valid_d;
  end

  always_ff @(posedge clk) begin
    if (req) begin
      pa       <= pa_d;
      status   <= status_d;
      uncached <= unc_d;
    end
  end
endmodule

// File: rtl/dtlb_varpage.sv
module dtlb_varpage
  import dtlb_pkg::*;
#(
  parameter int N_ENTRIES = 64,
  parameter int N_PORTS   = 2,
  localparam int IDX_W    = $clog2(N_ENTRIES)
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           cfg_we,
  input  logic [IDX_W-1:0]               cfg_idx,
  input  logic                           cfg_valid,
  input  logic [VPN_W-1:0]               cfg_vpn,
  input  logic [VPN_W-1:0]               cfg_ppn,
  input  logic [SZ_W-1:0]                cfg_size,
  input  logic [TID_W-1:0]               cfg_tid,
  input  logic                           cfg_wok,
  input  logic [N_PORTS-1:0]             lk_req,
  input  logic [N_PORTS-1:0][VA_W-1:0]   lk_va,
  input  logic [N_PORTS-1:0][TID_W-1:0]  lk_tid,
  input  logic [N_PORTS-1:0]             lk_store,
  input  logic [N_PORTS-1:0]             lk_sup,
  output logic [N_PORTS-1:0]             rs_valid,
  output logic [N_PORTS-1:0][VA_W-1:0]   rs_pa,
  output logic [N_PORTS-1:0][1:0]        rs_status,
  output logic [N_PORTS-1:0]             rs_uncached
);
  logic [N_ENTRIES-1:0] ents_valid;
  dtlb_map_t            ents [N_ENTRIES];

  for (genvar e = 0; e < N_ENTRIES; e++) begin : g_ent
    dtlb_entry #(.N_ENTRIES(N_ENTRIES), .SLOT(e)) u_ent (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_we    (cfg_we),
      .cfg_idx   (cfg_idx),
      .cfg_valid (cfg_valid),
      .cfg_vpn   (cfg_vpn),
      .cfg_ppn   (cfg_ppn),
      .cfg_size  (cfg_size),
      .cfg_tid   (cfg_tid),
      .cfg_wok   (cfg_wok),
      .ent_valid (ents_valid[e]),
      .ent_map   (ents[e])
    );
  end

  for (genvar p = 0; p < N_PORTS; p++) begin : g_port
    dtlb_status_e st;
    dtlb_lookup #(.N_ENTRIES(N_ENTRIES)) u_lk (
      .clk        (clk),
      .rst_n      (rst_n),
      .req        (lk_req[p]),
      .va         (lk_va[p]),
      .tid        (lk_tid[p]),
      .store      (lk_store[p]),
      .sup        (lk_sup[p]),
      .ents_valid (ents_valid),
      .ents       (ents),
      .rsp_valid  (rs_valid[p]),
      .pa         (rs_pa[p]),
      .status     (st),
      .uncached   (rs_uncached[p])
    );
    assign rs_status[p] = st;
  end
endmodule

// File: rtl/dtlb_checker.sv
module dtlb_checker
  import dtlb_pkg::*;
#(
  parameter int N_PORTS = 2
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic [N_PORTS-1:0]            lk_req,
  input logic [N_PORTS-1:0][VA_W-1:0]  lk_va,
  input logic [N_PORTS-1:0]            lk_sup,
  input logic [N_PORTS-1:0]            rs_valid,
  input logic [N_PORTS-1:0][VA_W-1:0]  rs_pa,
  input logic [N_PORTS-1:0][1:0]       rs_status,
  input logic [N_PORTS-1:0]            rs_uncached
);
  for (genvar p = 0; p < N_PORTS; p++) begin : g_chk
    a_r2_rsp_after_req: assert property (@(posedge clk) disable iff (!rst_n)
      lk_req[p] |=> rs_valid[p]);

    a_r2_no_spurious_rsp: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_req[p] |=> !rs_valid[p]);

    a_r7_user_sup_seg: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_req[p] && !lk_sup[p] && lk_va[p][VA_W-1]) |=> (rs_status[p] == 2'b11));

    a_r6_identity_seg: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_req[p] && lk_sup[p] && (lk_va[p][VA_W-1 -: 2] == 2'b10))
        |=> (rs_status[p] == 2'b00) && (rs_pa[p] == $past(lk_va[p])));

    a_r6_uncached_seg: assert property (@(posedge clk) disable iff (!rst_n)
      (rs_valid[p] && rs_uncached[p]) |-> ($past(lk_va[p][VA_W-1 -: SEG_W]) == 3'b101));

    a_r4_offset_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (rs_valid[p] && rs_status[p] == 2'b00)
        |-> (rs_pa[p][PAGE_LSB-1:0] == $past(lk_va[p][PAGE_LSB-1:0])));

    a_r3_fault_pa_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (rs_valid[p] && rs_status[p] != 2'b00) |-> (rs_pa[p] == '0));
  end
endmodule

bind dtlb_varpage dtlb_checker #(.N_PORTS(N_PORTS)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .lk_req      (lk_req),
  .lk_va       (lk_va),
  .lk_sup      (lk_sup),
  .rs_valid    (rs_valid),
  .rs_pa       (rs_pa),
  .rs_status   (rs_status),
  .rs_uncached (rs_uncached)
);

// File: tb/dtlb_varpage_bench.sv
`timescale 1ns/1ps
module dtlb_varpage_bench;
  localparam int NP = 2;
  localparam int NE = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic                  cfg_we = 0, cfg_valid = 0, cfg_wok = 0;
  logic [5:0]            cfg_idx = 0;
  logic [19:0]           cfg_vpn = 0, cfg_ppn = 0;
  logic [2:0]            cfg_size = 0;
  logic [7:0]            cfg_tid = 0;
  logic [NP-1:0]         lk_req = 0, lk_store = 0, lk_sup = 0;
  logic [NP-1:0][31:0]   lk_va = 0;
  logic [NP-1:0][7:0]    lk_tid = 0;
  logic [NP-1:0]         rs_valid, rs_uncached;
  logic [NP-1:0][31:0]   rs_pa;
  logic [NP-1:0][1:0]    rs_status;

  dtlb_varpage u_dtlb_varpage (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_valid(cfg_valid), .cfg_vpn(cfg_vpn),
    .cfg_ppn(cfg_ppn), .cfg_size(cfg_size), .cfg_tid(cfg_tid), .cfg_wok(cfg_wok),
    .lk_req(lk_req), .lk_va(lk_va), .lk_tid(lk_tid), .lk_store(lk_store), .lk_sup(lk_sup),
    .rs_valid(rs_valid), .rs_pa(rs_pa), .rs_status(rs_status), .rs_uncached(rs_uncached)
  );

  // reference entry store
  bit          m_valid [NE];
  logic [19:0] m_vpn [NE], m_ppn [NE];
  int          m_size [NE];
  logic [7:0]  m_tid [NE];
  bit          m_wok [NE];

  // stimulus for the next cycle
  bit          s_we, s_valid, s_wok;
  int          s_idx, s_size;
  logic [19:0] s_vpn, s_ppn;
  logic [7:0]  s_tid;
  bit          s_req [NP];
  logic [31:0] s_va [NP];
  logic [7:0]  s_ltid [NP];
  bit          s_store [NP], s_sup [NP];
  string       s_tag [NP];

  // expectations
  bit          e_v [NP];
  logic [31:0] e_pa [NP];
  logic [1:0]  e_st [NP];
  bit          e_unc [NP];
  string       e_tag [NP];

  int n_checks = 0, n_errors = 0;

  task automatic model(input int p);
    logic [31:0] v, off;
    logic [2:0]  top;
    int hits, first;
    v = s_va[p]; top = v[31:29];
    e_pa[p] = 32'h0; e_unc[p] = 0; e_st[p] = 2'b00;
    if (top[2] && !s_sup[p]) begin
      e_st[p] = 2'b11; e_tag[p] = "R7";
    end else if (top == 3'd4 || top == 3'd5) begin
      e_pa[p] = v; e_unc[p] = (top == 3'd5); e_tag[p] = "R6";
    end else begin
      hits = 0; first = -1; off = 0;
      for (int i = 0; i < NE; i++) begin
        logic [31:0] o;
        int sz;
        sz = (m_size[i] > 6) ? 6 : m_size[i];
        o = (32'h1000 << (2 * sz)) - 1;
        if (m_valid[i] && m_tid[i] == s_ltid[p] && ((v & ~o) == ({m_vpn[i], 12'h0} & ~o))) begin
          hits++;
          if (first < 0) begin first = i; off = o; end
        end
      end
      if (first < 0) begin
        e_st[p] = 2'b01; e_tag[p] = "R3";
      end else begin
        e_tag[p] = (hits > 1) ? "R9" : "R4";
        if (s_store[p] && !m_wok[first]) begin
          e_st[p] = 2'b10; e_tag[p] = (hits > 1) ? "R9" : "R5";
        end else begin
          e_pa[p] = ({m_ppn[first], 12'h0} & ~off) | (v & off);
        end
      end
    end
    if (s_tag[p] != "") e_tag[p] = s_tag[p];
  endtask

  task automatic tick();
    @(negedge clk);
    for (int p = 0; p < NP; p++) begin
      n_checks++;
      if (rs_valid[p] !== e_v[p]) begin
        n_errors++;
        $display("FAIL R2 port %0d rs_valid got %b exp %b", p, rs_valid[p], e_v[p]);
      end
      if (e_v[p]) begin
        n_checks++;
        if (rs_status[p] !== e_st[p] || rs_pa[p] !== e_pa[p] || rs_uncached[p] !== e_unc[p]) begin
          n_errors++;
          $display("FAIL %s port %0d got st=%b pa=%h unc=%b exp st=%b pa=%h unc=%b",
                   e_tag[p], p, rs_status[p], rs_pa[p], rs_uncached[p],
                   e_st[p], e_pa[p], e_unc[p]);
        end
      end
    end
    for (int p = 0; p < NP; p++) begin
      e_v[p] = s_req[p];
      if (s_req[p]) model(p);
    end
    if (s_we) begin
      m_valid[s_idx] = s_valid; m_vpn[s_idx] = s_vpn; m_ppn[s_idx] = s_ppn;
      m_size[s_idx] = s_size; m_tid[s_idx] = s_tid; m_wok[s_idx] = s_wok;
    end
    cfg_we = s_we; cfg_idx = 6'(s_idx); cfg_valid = s_valid; cfg_vpn = s_vpn;
    cfg_ppn = s_ppn; cfg_size = 3'(s_size); cfg_tid = s_tid; cfg_wok = s_wok;
    for (int p = 0; p < NP; p++) begin
      lk_req[p] = s_req[p]; lk_va[p] = s_va[p]; lk_tid[p] = s_ltid[p];
      lk_store[p] = s_store[p]; lk_sup[p] = s_sup[p];
      s_req[p] = 0; s_store[p] = 0; s_sup[p] = 0; s_tag[p] = "";
    end
    s_we = 0;
  endtask

  task automatic wr(input int idx, input bit vld, input logic [19:0] vpn, input logic [19:0] ppn,
                    input int size, input logic [7:0] tid, input bit wok);
    s_we = 1; s_idx = idx; s_valid = vld; s_vpn = vpn; s_ppn = ppn;
    s_size = size; s_tid = tid; s_wok = wok;
  endtask

  task automatic lk(input int p, input logic [31:0] va, input logic [7:0] tid,
                    input bit st, input bit sup);
    s_req[p] = 1; s_va[p] = va; s_ltid[p] = tid; s_store[p] = st; s_sup[p] = sup;
  endtask

  bit done = 0;
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  logic [19:0] pool [8] = '{20'h00010, 20'h00011, 20'h00200, 20'h05000,
                            20'h60000, 20'h80000, 20'hA0000, 20'h05400};

  initial begin
    for (int i = 0; i < NE; i++) begin
      m_valid[i] = 0; m_vpn[i] = 0; m_ppn[i] = 0; m_size[i] = 0; m_tid[i] = 0; m_wok[i] = 0;
    end
    for (int p = 0; p < NP; p++) begin
      e_v[p] = 0; s_req[p] = 0; s_store[p] = 0; s_sup[p] = 0; s_tag[p] = ""; s_va[p] = 0; s_ltid[p] = 0;
    end
    s_we = 0; s_idx = 0; s_valid = 0; s_vpn = 0; s_ppn = 0; s_size = 0; s_tid = 0; s_wok = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state, then a mapped lookup misses
    tick();
    s_tag[0] = "R1"; lk(0, 32'h0001_0234, 8'd5, 0, 0);
    s_tag[1] = "R1"; lk(1, 32'h0500_0000, 8'd5, 0, 1);
    tick();

    // R8: write entry 0 while looking it up: old contents apply
    wr(0, 1, 20'h00010, 20'h00ABC, 0, 8'd5, 1);
    s_tag[0] = "R8"; lk(0, 32'h0001_0234, 8'd5, 0, 0);
    tick();
    lk(0, 32'h0001_0234, 8'd5, 1, 0);            // R4: 4 KB hit
    lk(1, 32'h0001_0234, 8'd6, 0, 0);            // R3: wrong task
    tick();
    lk(0, 32'h0001_1234, 8'd5, 0, 0);            // R3: next page
    wr(1, 1, 20'h00200, 20'h01230, 2, 8'd5, 0);  // 64 KB, read-only
    tick();
    lk(0, 32'h0020_ABCD, 8'd5, 0, 0);            // R4: 64 KB load
    lk(1, 32'h0020_ABCD, 8'd5, 1, 0);            // R5: store to read-only
    wr(2, 1, 20'h05000, 20'h7A000, 6, 8'd5, 1);  // 16 MB
    tick();
    lk(0, 32'h05AB_CDEF, 8'd5, 0, 0);            // R4: 16 MB
    wr(3, 1, 20'h09000, 20'h3B000, 7, 8'd5, 1);  // code 7 acts as 16 MB
    tick();
    lk(0, 32'h09FE_DCBA, 8'd5, 0, 0);            // R4: code 7
    lk(1, 32'h8123_4567, 8'd0, 0, 1);            // R6: identity cached
    tick();
    lk(0, 32'hA123_4567, 8'd0, 1, 1);            // R6: identity uncached
    lk(1, 32'hA123_4567, 8'd0, 0, 0);            // R7: user to supervisor segment
    wr(4, 1, 20'hC0001, 20'h00042, 0, 8'd9, 0);
    tick();
    lk(0, 32'hC000_1010, 8'd9, 0, 1);            // R6: supervisor mapped segment
    lk(1, 32'hC000_1010, 8'd9, 1, 0);            // R7: priority over PROT
    wr(9, 1, 20'h00010, 20'h0FFFF, 0, 8'd5, 0);  // shadowed duplicate of entry 0
    tick();
    lk(0, 32'h0001_0FFC, 8'd5, 1, 0);            // R9: entry 0 wins, store allowed
    wr(0, 0, 20'h00010, 20'h00ABC, 0, 8'd5, 1);  // R8: invalidate entry 0
    tick();
    lk(0, 32'h0001_0FFC, 8'd5, 1, 0);            // R8: now entry 9, PROT
    lk(1, 32'h0001_0FFC, 8'd5, 0, 0);
    tick();

    // random mix over a few overlapping pages
    for (int k = 0; k < 600; k++) begin
      if ($urandom_range(0, 2) == 0)
        wr($urandom_range(0, 15), $urandom_range(0, 5) != 0, pool[$urandom_range(0, 7)],
           20'($urandom), $urandom_range(0, 7), 8'($urandom_range(1, 2)), $urandom_range(0, 1) == 1);
      for (int p = 0; p < NP; p++) begin
        if ($urandom_range(0, 3) != 0)
          lk(p, {pool[$urandom_range(0, 7)], 12'h0} ^ ($urandom & 32'h003F_FFFF),
             8'($urandom_range(1, 2)), $urandom_range(0, 1) == 1, $urandom_range(0, 3) != 0);
      end
      tick();
    end
    tick();
    tick();

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule